// File: doc/BRIEF.md
# Streaming-to-Memory-Mapped Request Bridge

This bridge sits between a packet stream of simple memory requests and a single-word memory-mapped port shared by two target functions. Each request packet starts with a header beat that holds an opcode, a function index and a word address. A write request adds a data beat. The bridge turns each request into exactly one memory-mapped access. The access goes to the target function through that function's own select strobe.

For a read, the bridge waits for the target function to return a data-valid pulse with the word. It then sends the word upstream as a one-beat completion packet on a transmit stream. The bridge serves one request at a time, and it throttles the receive stream while a request is in progress.

Top module: `st2mm_bridge`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and in the cycle after it is released, `rx_ready` is high and `mm_write`, `mm_read`, `mm_sel` and `tx_valid` are all low.
- R2: A header beat is accepted only on a cycle where `rx_valid`, `rx_sop` and `rx_ready` are all high. The header fields are:
  - bit 31 is the opcode (1 = write, 0 = read);
  - bit 30 is the function index;
  - bits 15:0 are the word address.
  - A valid beat in idle without `rx_sop` is ignored: no access follows and `rx_ready` stays high.
- R3: Write sequence:
  - After a write header, `rx_ready` stays high for the data beat, and the beat with `rx_eop` high supplies the 32-bit write data.
  - In the cycle after that beat, `mm_write` is high for exactly one cycle, with `mm_addr` and `mm_wdata` valid.
  - The bridge is then idle again.
- R4: In the cycle after a read header is accepted, `mm_read` is high for exactly one cycle, with `mm_addr` equal to the header address.
- R5: Read data is captured only from an `mm_rvalid` pulse that arrives after `mm_read` has dropped and while the read is outstanding.
- R6: The completion beat has `tx_valid`, `tx_sop` and `tx_eop` high in the same cycle, and `tx_data` equals the captured read word. It appears in the cycle after the capturing `mm_rvalid` pulse.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R8: `rx_ready` is low during the following periods:
  - from the cycle after a read header is accepted until the cycle after the completion beat is taken (`tx_valid` and `tx_ready` both high);
  - during the write-issue cycle.
- R9: `mm_sel` has at most one bit high. Bit f is high in these cycles:
  - during the write-issue cycle for function f;
  - during the read strobe and while the read to function f is outstanding.
  - `mm_sel` is zero when the bridge is idle.
- R10: An `mm_rvalid` pulse that arrives while no read is outstanding is ignored. No completion is produced, and the next real read returns its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Bridge can take a receive beat |
| rx_sop | input | 1 | Receive start of packet |
| rx_eop | input | 1 | Receive end of packet |
| rx_data | input | 32 | Receive beat: header or write data |
| mm_sel | output | 2 | One select strobe per target function |
| mm_addr | output | 16 | Word address of the access |
| mm_write | output | 1 | Write strobe |
| mm_wdata | output | 32 | Write data |
| mm_read | output | 1 | Read strobe |
| mm_rvalid | input | 1 | Read data valid from the selected function |
| mm_rdata | input | 32 | Read data from the selected function |
| tx_valid | output | 1 | Completion beat valid |
| tx_ready | input | 1 | Downstream can take the completion |
| tx_sop | output | 1 | Completion start of packet |
| tx_eop | output | 1 | Completion end of packet |
| tx_data | output | 32 | Completion data |

## Verification
A sequencer stuck in a wrong state shows up within one cycle as a problem at the ports:
- a stuck `rx_ready` level;
- a strobe that lasts two cycles or is missing;
- a select on the wrong function.

A completion register that is loaded at the wrong time shows up as changed `tx_data` while the beat is stalled. It also shows up when a stray read-data pulse leaks into a completion, which is visible on the first idle cycle after the stray pulse. Header fields latched from the wrong bits show up as a wrong address or function on the very next strobe.

// File: rtl/st2mm_pkg.sv
package st2mm_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_WBEAT = 3'd1,
        SQ_WISSUE = 3'd2,
        SQ_RISSUE = 3'd3,
        SQ_RWAIT = 3'd4,
        SQ_CPL   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic rx_ready;
        logic hdr_load;
        logic wdata_load;
        logic cpl_load;
        logic wr_strobe;
        logic rd_strobe;
        logic access;
    } seq_ctrl_t;

endpackage

// File: rtl/st2mm_seq.sv
module st2mm_seq
    import st2mm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_valid,
    input  logic      rx_sop,
    input  logic      rx_eop,
    input  logic      hdr_is_write,
    input  logic      mm_rvalid,
    input  logic      tx_ready,
    output seq_ctrl_t ctrl
);

    typedef struct packed {
        seq_state_e st;
    } seq_reg_t;

    seq_reg_t r_q, r_d;

    always_comb begin
        ctrl            = '0;
        ctrl.rx_ready   = (r_q.st == SQ_IDLE) || (r_q.st == SQ_WBEAT);
        ctrl.hdr_load   = (r_q.st == SQ_IDLE) && rx_valid && rx_sop;
        ctrl.wdata_load = (r_q.st == SQ_WBEAT) && rx_valid;
        ctrl.cpl_load   = (r_q.st == SQ_RWAIT) && mm_rvalid;
        ctrl.wr_strobe  = (r_q.st == SQ_WISSUE);
        ctrl.rd_strobe  = (r_q.st == SQ_RISSUE);
        ctrl.access     = (r_q.st == SQ_WISSUE) || (r_q.st == SQ_RISSUE)
                       || (r_q.st == SQ_RWAIT);
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SQ_IDLE: begin
                if (ctrl.hdr_load) begin
                    r_d.st = hdr_is_write ? SQ_WBEAT : SQ_RISSUE;
                end
            end
            SQ_WBEAT: begin
                if (rx_valid && rx_eop) begin
                    r_d.st = SQ_WISSUE;
                end
            end
            SQ_WISSUE: r_d.st = SQ_IDLE;
            SQ_RISSUE: r_d.st = SQ_RWAIT;
            SQ_RWAIT: begin
                if (mm_rvalid) begin
                    r_d.st = SQ_CPL;
                end
            end
            SQ_CPL: begin
                if (tx_ready) begin
                    r_d.st = SQ_IDLE;
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st <= SQ_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/st2mm_req_capture.sv
module st2mm_req_capture #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int FUNC_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_load,
    input  logic              wdata_load,
    input  logic [DATA_W-1:0] rx_data,
    output logic              hdr_is_write,
    output logic [FUNC_W-1:0] func_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    localparam int OP_POS   = DATA_W - 1;
    localparam int FUNC_TOP = DATA_W - 2;

    typedef struct packed {
        logic [FUNC_W-1:0] func;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cap_reg_t;

    cap_reg_t c_q, c_d;

    assign hdr_is_write = rx_data[OP_POS];

    always_comb begin
        c_d = c_q;
        if (hdr_load) begin
            c_d.func = rx_data[FUNC_TOP -: FUNC_W];
            c_d.addr = rx_data[ADDR_W-1:0];
        end
        if (wdata_load) begin
            c_d.wdata = rx_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign func_q  = c_q.func;
    assign addr_q  = c_q.addr;
    assign wdata_q = c_q.wdata;

endmodule

// File: rtl/st2mm_func_sel.sv
module st2mm_func_sel #(
    parameter int NUM_FUNC = 2,
    parameter int FUNC_W   = 1
) (
    input  logic                active,
    input  logic [FUNC_W-1:0]   func,
    output logic [NUM_FUNC-1:0] sel
);

    for (genvar i = 0; i < NUM_FUNC; i++) begin : g_sel
        assign sel[i] = active && (func == FUNC_W'(i));
    end

endmodule

// File: rtl/st2mm_cpl_out.sv
module st2mm_cpl_out #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpl_load,
    input  logic [DATA_W-1:0] mm_rdata,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cpl_reg_t;

    cpl_reg_t o_q, o_d;

    always_comb begin
        o_d = o_q;
        if (cpl_load) begin
            o_d.valid = 1'b1;
            o_d.data  = mm_rdata;
        end else if (o_q.valid && tx_ready) begin
            o_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign tx_valid = o_q.valid;
    assign tx_data  = o_q.data;

endmodule

// File: rtl/st2mm_bridge.sv
module st2mm_bridge
    import st2mm_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 16,
    parameter int NUM_FUNC = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_valid,
    output logic                rx_ready,
    input  logic                rx_sop,
    input  logic                rx_eop,
    input  logic [DATA_W-1:0]   rx_data,
    output logic [NUM_FUNC-1:0] mm_sel,
    output logic [ADDR_W-1:0]   mm_addr,
    output logic                mm_write,
    output logic [DATA_W-1:0]   mm_wdata,
    output logic                mm_read,
    input  logic                mm_rvalid,
    input  logic [DATA_W-1:0]   mm_rdata,
    output logic                tx_valid,
    input  logic                tx_ready,
    output logic                tx_sop,
    output logic                tx_eop,
    output logic [DATA_W-1:0]   tx_data
);

    localparam int FUNC_W = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1;

    seq_ctrl_t          ctrl;
    logic               hdr_is_write;
    logic [FUNC_W-1:0]  func_q;

    st2mm_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .rx_valid     (rx_valid),
        .rx_sop       (rx_sop),
        .rx_eop       (rx_eop),
        .hdr_is_write (hdr_is_write),
        .mm_rvalid    (mm_rvalid),
        .tx_ready     (tx_ready),
        .ctrl         (ctrl)
    );

    st2mm_req_capture #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .FUNC_W (FUNC_W)
    ) u_cap (
        .clk          (clk),
        .rst          (rst),
        .hdr_load     (ctrl.hdr_load),
        .wdata_load   (ctrl.wdata_load),
        .rx_data      (rx_data),
        .hdr_is_write (hdr_is_write),
        .func_q       (func_q),
        .addr_q       (mm_addr),
        .wdata_q      (mm_wdata)
    );

    st2mm_func_sel #(
        .NUM_FUNC (NUM_FUNC),
        .FUNC_W   (FUNC_W)
    ) u_sel (
        .active (ctrl.access),
        .func   (func_q),
        .sel    (mm_sel)
    );

    st2mm_cpl_out #(
        .DATA_W (DATA_W)
    ) u_cpl (
        .clk      (clk),
        .rst      (rst),
        .cpl_load (ctrl.cpl_load),
        .mm_rdata (mm_rdata),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    assign rx_ready = ctrl.rx_ready;
    assign mm_write = ctrl.wr_strobe;
    assign mm_read  = ctrl.rd_strobe;
    assign tx_sop   = tx_valid;
    assign tx_eop   = tx_valid;

endmodule

// File: rtl/st2mm_bridge_chk.sv
module st2mm_bridge_chk #(
    parameter int DATA_W   = 32,
    parameter int NUM_FUNC = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                rx_valid,
    input logic                rx_sop,
    input logic                rx_ready,
    input logic                mm_read,
    input logic                mm_write,
    input logic [NUM_FUNC-1:0] mm_sel,
    input logic                tx_valid,
    input logic                tx_ready,
    input logic                tx_sop,
    input logic                tx_eop,
    input logic [DATA_W-1:0]   tx_data
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rx_ready && !mm_read && !mm_write && mm_sel == '0 && !tx_valid));

    assert_read_after_hdr_R4: assert property (@(posedge clk) disable iff (rst)
        mm_read |-> $past(rx_valid && rx_sop && rx_ready));

    assert_read_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        mm_read |=> !mm_read);

    assert_write_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        mm_write |=> !mm_write);

    assert_cpl_frame_R6: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_sop && tx_eop));

    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (mm_read || mm_write || tx_valid) |-> !rx_ready);

    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mm_sel));

    assert_strobe_sel_R9: assert property (@(posedge clk) disable iff (rst)
        (mm_read || mm_write) |-> ($countones(mm_sel) == 1));

endmodule

bind st2mm_bridge st2mm_bridge_chk #(
    .DATA_W   (DATA_W),
    .NUM_FUNC (NUM_FUNC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_sop   (rx_sop),
    .rx_ready (rx_ready),
    .mm_read  (mm_read),
    .mm_write (mm_write),
    .mm_sel   (mm_sel),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_sop   (tx_sop),
    .tx_eop   (tx_eop),
    .tx_data  (tx_data)
);

// File: tb/tb_st2mm_bridge.sv
module tb_st2mm_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_valid, rx_sop, rx_eop;
    logic        rx_ready;
    logic [31:0] rx_data;
    logic [1:0]  mm_sel;
    logic [15:0] mm_addr;
    logic        mm_write, mm_read, mm_rvalid;
    logic [31:0] mm_wdata, mm_rdata;
    logic        tx_valid, tx_ready, tx_sop, tx_eop;
    logic [31:0] tx_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    st2mm_bridge dut (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_data(rx_data),
        .mm_sel(mm_sel), .mm_addr(mm_addr), .mm_write(mm_write),
        .mm_wdata(mm_wdata), .mm_read(mm_read), .mm_rvalid(mm_rvalid),
        .mm_rdata(mm_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .tx_data(tx_data)
    );

    // {is_write, func, addr, data, tx stall cycles}
    typedef struct packed {
        logic        wr;
        logic        fn;
        logic [15:0] addr;
        logic [31:0] data;
        logic [3:0]  stall;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b0, 16'h0010, 32'hDEAD_BEEF, 4'd0},
        '{1'b1, 1'b1, 16'hFFFF, 32'h0123_4567, 4'd0},
        '{1'b0, 1'b0, 16'h0010, 32'hCAFE_F00D, 4'd0},
        '{1'b0, 1'b1, 16'h8001, 32'hA5A5_5A5A, 4'd3},
        '{1'b1, 1'b1, 16'h0000, 32'hFFFF_FFFF, 4'd0},
        '{1'b0, 1'b1, 16'h1234, 32'h0000_0001, 4'd1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr(input logic wr, input logic fn, input logic [15:0] a);
        return {wr, fn, 14'b0, a};
    endfunction

    task automatic do_write(input logic fn, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_sop = 1'b1; rx_eop = 1'b0; rx_data = hdr(1'b1, fn, a);
        check("R2 ready at header", 64'(rx_ready), 64'd1);
        @(negedge clk);
        rx_sop = 1'b0; rx_eop = 1'b1; rx_data = d;
        check("R3 ready for data beat", 64'(rx_ready), 64'd1);
        @(negedge clk);
        rx_valid = 1'b0; rx_eop = 1'b0; rx_data = '0;
        check("R3 write strobe", 64'(mm_write), 64'd1);
        check("R3 write addr", 64'(mm_addr), 64'(a));
        check("R3 write data", 64'(mm_wdata), 64'(d));
        check("R9 write sel", 64'(mm_sel), 64'(2'b01 << fn));
        check("R8 ready low during write", 64'(rx_ready), 64'd0);
        @(negedge clk);
        check("R3 write done", 64'({mm_write, mm_sel}), 64'd0);
        check("R3 idle ready", 64'(rx_ready), 64'd1);
    endtask

    task automatic do_read(input logic fn, input logic [15:0] a, input logic [31:0] d,
                           input int stall);
        @(negedge clk);
        rx_valid = 1'b1; rx_sop = 1'b1; rx_eop = 1'b1; rx_data = hdr(1'b0, fn, a);
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_data = '0;
        check("R4 read strobe", 64'(mm_read), 64'd1);
        check("R4 read addr", 64'(mm_addr), 64'(a));
        check("R9 read sel", 64'(mm_sel), 64'(2'b01 << fn));
        check("R8 ready low after read hdr", 64'(rx_ready), 64'd0);
        @(negedge clk);
        check("R5 strobe dropped", 64'(mm_read), 64'd0);
        check("R9 sel held while waiting", 64'(mm_sel), 64'(2'b01 << fn));
        mm_rvalid = 1'b1; mm_rdata = d;
        @(negedge clk);
        mm_rvalid = 1'b0; mm_rdata = 32'h5555_0000;
        check("R6 cpl frame", 64'({tx_valid, tx_sop, tx_eop}), 64'b111);
        check("R6 cpl data", 64'(tx_data), 64'(d));
        check("R9 sel idle at cpl", 64'(mm_sel), 64'd0);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check("R7 held valid", 64'(tx_valid), 64'd1);
            check("R7 held data", 64'(tx_data), 64'(d));
            check("R8 ready low while cpl pending", 64'(rx_ready), 64'd0);
        end
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        check("R8 ready back after cpl", 64'(rx_ready), 64'd1);
        check("R6 cpl gone", 64'(tx_valid), 64'd0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected<20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        rst = 1'b1;
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_data = '0;
        mm_rvalid = 1'b0; mm_rdata = '0; tx_ready = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset ready", 64'(rx_ready), 64'd1);
        check("R1 reset strobes", 64'({mm_write, mm_read, mm_sel, tx_valid}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", 64'({rx_ready, mm_write, mm_read, mm_sel, tx_valid}), 64'b1_0_0_00_0);

        foreach (VECS[k]) begin
            if (VECS[k].wr) do_write(VECS[k].fn, VECS[k].addr, VECS[k].data);
            else            do_read(VECS[k].fn, VECS[k].addr, VECS[k].data, int'(VECS[k].stall));
        end

        // R2: valid beat without sop in idle is ignored
        @(negedge clk);
        rx_valid = 1'b1; rx_sop = 1'b0; rx_eop = 1'b1; rx_data = hdr(1'b0, 1'b1, 16'h0042);
        @(negedge clk);
        rx_valid = 1'b0; rx_eop = 1'b0;
        check("R2 no-sop ignored strobe", 64'({mm_read, mm_write, mm_sel}), 64'd0);
        check("R2 no-sop ready stays", 64'(rx_ready), 64'd1);

        // R10: stray read-data pulse in idle is ignored
        mm_rvalid = 1'b1; mm_rdata = 32'hBAD0_BAD0;
        @(negedge clk);
        mm_rvalid = 1'b0;
        @(negedge clk);
        check("R10 stray no completion", 64'(tx_valid), 64'd0);
        check("R10 stray ready", 64'(rx_ready), 64'd1);
        do_read(1'b0, 16'h0777, 32'h1357_9BDF, 0);

        // R3: write with an extra beat before eop writes the last beat
        @(negedge clk);
        rx_valid = 1'b1; rx_sop = 1'b1; rx_eop = 1'b0; rx_data = hdr(1'b1, 1'b0, 16'h0A0A);
        @(negedge clk);
        rx_sop = 1'b0; rx_data = 32'h1111_1111;
        @(negedge clk);
        check("R3 no write before eop", 64'(mm_write), 64'd0);
        rx_eop = 1'b1; rx_data = 32'h2222_2222;
        @(negedge clk);
        rx_valid = 1'b0; rx_eop = 1'b0;
        check("R3 write on eop beat", 64'({mm_write, mm_wdata}), {31'd0, 1'b1, 32'h2222_2222});

        // R1: reset during a pending completion returns to idle
        do_write(1'b1, 16'h0001, 32'h0);
        @(negedge clk);
        rx_valid = 1'b1; rx_sop = 1'b1; rx_eop = 1'b1; rx_data = hdr(1'b0, 1'b1, 16'h0002);
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
        @(negedge clk);
        mm_rvalid = 1'b1; mm_rdata = 32'h7777_7777;
        @(negedge clk);
        mm_rvalid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-cpl reset", 64'({rx_ready, tx_valid, mm_sel}), 64'b1_0_00);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule